// File: doc/BRIEF.md
# Configurable 32-Source Interrupt Hub

The hub collects 32 interrupt inputs and turns them into two request lines and one wake line. Each input has its own trigger type: off, rising edge, falling edge, either edge, high level or low level. Edge events go into two separate latch words, one for rising and one for falling. These latches hold until software clears them. Level events follow the input directly. A mask word gates each source onto the request lines, and an assign word picks which of the two lines a source drives. A wake-enable word selects which sources, masked or not, raise the wake line.

Software reaches every control word over a plain 32-bit register bus. Each word is changed through a pair of addresses, one that sets the bits written as 1 and one that clears them. The two pending words share addresses with two of the clear registers. Reads return the pending word, and writes act as clears. A source-select word picks, per source, whether the external pin or a bit of a test register feeds the trigger logic. This lets software inject interrupts without driving the pins.

Top module: `ic_hub`

## Requirements
- R1: For source n, the trigger code is {cfg2[n], cfg1[n], cfg0[n]}. The codes are 001 rising edge, 010 falling edge, 011 either edge, 101 high level and 110 low level. The codes 000, 100 and 111 produce no pending state and latch no edge.
- R2: Each control word changes only through its set and clear addresses. The set addresses are cfg0 0x40, cfg1 0x48, cfg2 0x50, source-select 0x58, assign 0x60, wake-enable 0x68 and mask 0x70. Each clear address is its set address plus 4. Only bits written as 1 change, and bits written as 0 keep their value.
- R3: A read at a set address returns that control word. A read at 0x54 returns pending word 0, and a read at 0x5C returns pending word 1. Writes to 0x54 and 0x5C still clear cfg2 and source-select. Reads at 0x44, 0x4C, 0x64, 0x6C and 0x74 return 0.
- R4: Source-select bit n = 1 feeds source n from pin n. Bit n = 0 feeds it from bit n of the test register at 0x80, and pin n is then ignored. The test register is loaded by a plain write and reads back at 0x80.
- R5: A rising edge is latched at 0x78 only under codes 001 and 011. A falling edge is latched at 0x7C only under codes 010 and 011. A latched bit holds until a 1 is written to it at the same address.
- R6: Under codes 101 and 110, a source is active while its synchronised input is high (101) or low (110). It stops being active on its own when the input changes, and it sets no latch.
- R7: A source is pending when it is active and its mask bit is 1. Assign bit 1 routes it to pending word 0 and request 0. Assign bit 0 routes it to pending word 1 and request 1. Each request is the OR of its pending word.
- R8: The wake output is the OR over all sources of (active AND wake-enable bit). The mask has no effect on it.
- R9: Inputs pass through a two-stage synchroniser. A level change on an input shows at the request output after the second clock edge, and a latched edge after the third.
- R10: After reset, every control word, latch word and the test register read 0, and all three outputs are low.
- R11: A safe-idle sequence puts the hub in a state where source-select reads all ones and no request is raised. The sequence writes all ones to every clear address and to the source-select set address, and writes 0 to the test register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_pins | input | 32 | External interrupt inputs, asynchronous |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wake line |

## Verification
Each trigger code is tried with both input transitions. Edge codes must latch one direction and ignore the other. Level codes must drop pending once the input returns, with no software action. The codes 100 and 111 are tried with the pin held high, which sets them apart from the level codes they resemble. The mask is cleared while wake-enable is set, which separates the wake path from the request path. Routing is checked by sending one source to each request line. The test register drives a source while its pin moves, which shows that the select bit really cuts the pin off.

// File: rtl/ic_pkg.sv
// Package: shared constants and types for the interrupt hub.
// Assumes the register bus is as wide as the source count (one bit per source).
package ic_pkg;
    localparam int ADDR_W  = 8;
    localparam int NUM_CTL = 7;

    // Indices of the set/clear control words; offset = 0x40 + 8*index
    localparam int W_CFG0 = 0;
    localparam int W_CFG1 = 1;
    localparam int W_CFG2 = 2;
    localparam int W_SRC  = 3;
    localparam int W_ASGN = 4;
    localparam int W_WAKE = 5;
    localparam int W_MASK = 6;

    localparam logic [ADDR_W-1:0] OFS_BASE  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_PEND0 = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_PEND1 = 8'h5C;
    localparam logic [ADDR_W-1:0] OFS_RISE  = 8'h78;
    localparam logic [ADDR_W-1:0] OFS_FALL  = 8'h7C;
    localparam logic [ADDR_W-1:0] OFS_TEST  = 8'h80;

    typedef enum logic [2:0] {
        TRIG_OFF  = 3'b000,
        TRIG_RISE = 3'b001,
        TRIG_FALL = 3'b010,
        TRIG_BOTH = 3'b011,
        TRIG_HIGH = 3'b101,
        TRIG_LOW  = 3'b110
    } trig_e;

    // Set address of control word idx
    function automatic logic [ADDR_W-1:0] set_ofs(input int unsigned idx);
        return OFS_BASE + ADDR_W'(idx * 8);
    endfunction

    // Clear address of control word idx
    function automatic logic [ADDR_W-1:0] clr_ofs(input int unsigned idx);
        return OFS_BASE + ADDR_W'(idx * 8 + 4);
    endfunction
endpackage

// File: rtl/ic_regs.sv
// Module: control register file of the interrupt hub.
// Holds the seven set/clear words and the test register, and emits one-cycle
// clear pulses for the edge latches. Assumes one write per cycle on the bus.
module ic_regs
    import ic_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [N_SRC-1:0]              bus_wdata,
    output logic [NUM_CTL-1:0][N_SRC-1:0] ctl_o,
    output logic [N_SRC-1:0]              test_o,
    output logic [N_SRC-1:0]              rise_clr_o,
    output logic [N_SRC-1:0]              fall_clr_o
);
    logic [NUM_CTL-1:0][N_SRC-1:0] ctl_q;
    logic [N_SRC-1:0]              test_q;

    for (genvar g = 0; g < NUM_CTL; g++) begin : g_word
        // Update one control word: OR in set writes, AND out clear writes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q[g] <= '0;
            end else if (bus_wr && bus_addr == set_ofs(g)) begin
                ctl_q[g] <= ctl_q[g] | bus_wdata;
            end else if (bus_wr && bus_addr == clr_ofs(g)) begin
                ctl_q[g] <= ctl_q[g] & ~bus_wdata;
            end
        end

        assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == set_ofs(g)) |=>
                ((ctl_q[g] & $past(bus_wdata)) == $past(bus_wdata)) &&
                ((ctl_q[g] & ~$past(bus_wdata)) == ($past(ctl_q[g]) & ~$past(bus_wdata))));

        assert_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == clr_ofs(g)) |=>
                ((ctl_q[g] & $past(bus_wdata)) == '0) &&
                ((ctl_q[g] & ~$past(bus_wdata)) == ($past(ctl_q[g]) & ~$past(bus_wdata))));
    end

    // Load the test register with a plain write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_q <= '0;
        end else if (bus_wr && bus_addr == OFS_TEST) begin
            test_q <= bus_wdata;
        end
    end

    // Turn writes at the latch addresses into clear pulses
    always_comb begin
        rise_clr_o = (bus_wr && bus_addr == OFS_RISE) ? bus_wdata : '0;
        fall_clr_o = (bus_wr && bus_addr == OFS_FALL) ? bus_wdata : '0;
    end

    assign ctl_o  = ctl_q;
    assign test_o = test_q;
endmodule

// File: rtl/ic_trig_cell.sv
// Module: trigger logic for one source.
// Synchronises the input, detects edges, holds the rising and falling latches
// and decodes level activity from the 3-bit trigger code.
// Assumes SYNC_STAGES >= 2 and an input that may change at any time.
module ic_trig_cell
    import ic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_i,
    input  logic [2:0] code_i,
    input  logic       rise_clr_i,
    input  logic       fall_clr_i,
    output logic       rise_lat_o,
    output logic       fall_lat_o,
    output logic       level_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   s;
    logic                   rise_ev, fall_ev, rise_en, fall_en;

    assign s = sync_q[SYNC_STAGES-1];

    // Shift the input through the synchroniser and keep the last sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], in_i};
            prev_q <= s;
        end
    end

    // Decode edge events and which edges the code enables
    always_comb begin
        rise_ev = s & ~prev_q;
        fall_ev = ~s & prev_q;
        rise_en = (code_i == TRIG_RISE) || (code_i == TRIG_BOTH);
        fall_en = (code_i == TRIG_FALL) || (code_i == TRIG_BOTH);
        level_o = ((code_i == TRIG_HIGH) && s) || ((code_i == TRIG_LOW) && !s);
    end

    // Edge latches: a new edge wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_lat_o <= 1'b0;
            fall_lat_o <= 1'b0;
        end else begin
            if (rise_ev && rise_en)   rise_lat_o <= 1'b1;
            else if (rise_clr_i)      rise_lat_o <= 1'b0;
            if (fall_ev && fall_en)   fall_lat_o <= 1'b1;
            else if (fall_clr_i)      fall_lat_o <= 1'b0;
        end
    end

    assert_rise_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_lat_o && !rise_clr_i) |=> rise_lat_o);

    assert_fall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_lat_o && !fall_clr_i) |=> fall_lat_o);

    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == TRIG_OFF && !rise_lat_o && !fall_lat_o) |=> (!rise_lat_o && !fall_lat_o));
endmodule

// File: rtl/ic_hub.sv
// Module: top of the 32-source interrupt hub.
// Combines the register file with one trigger cell per source, forms the two
// pending words, the request lines and the wake line, and serves bus reads.
// Assumes reads are combinational and have no side effects.
module ic_hub
    import ic_pkg::*;
#(
    parameter int N_SRC       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       irq_pins,
    output logic              req0_o,
    output logic              req1_o,
    output logic              wake_o
);
    logic [NUM_CTL-1:0][N_SRC-1:0] ctl;
    logic [N_SRC-1:0] test_w, rise_clr, fall_clr;
    logic [N_SRC-1:0] rise_lat, fall_lat, level_act, active, cell_in;
    logic [N_SRC-1:0] pend0, pend1;

    ic_regs #(.N_SRC(N_SRC)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .ctl_o      (ctl),
        .test_o     (test_w),
        .rise_clr_o (rise_clr),
        .fall_clr_o (fall_clr)
    );

    for (genvar n = 0; n < N_SRC; n++) begin : g_src
        assign cell_in[n] = ctl[W_SRC][n] ? irq_pins[n] : test_w[n];

        ic_trig_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_i       (cell_in[n]),
            .code_i     ({ctl[W_CFG2][n], ctl[W_CFG1][n], ctl[W_CFG0][n]}),
            .rise_clr_i (rise_clr[n]),
            .fall_clr_i (fall_clr[n]),
            .rise_lat_o (rise_lat[n]),
            .fall_lat_o (fall_lat[n]),
            .level_o    (level_act[n])
        );
    end

    // Form activity, pending words and the three outputs
    always_comb begin
        active = rise_lat | fall_lat | level_act;
        pend0  = active & ctl[W_MASK] & ctl[W_ASGN];
        pend1  = active & ctl[W_MASK] & ~ctl[W_ASGN];
        req0_o = |pend0;
        req1_o = |pend1;
        wake_o = |(active & ctl[W_WAKE]);
    end

    // Select read data by offset
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CTL; i++) begin
            if (bus_addr == set_ofs(i)) bus_rdata = ctl[i];
        end
        case (bus_addr)
            OFS_PEND0: bus_rdata = pend0;
            OFS_PEND1: bus_rdata = pend1;
            OFS_RISE:  bus_rdata = rise_lat;
            OFS_FALL:  bus_rdata = fall_lat;
            OFS_TEST:  bus_rdata = test_w;
            default:   ;
        endcase
    end

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[W_MASK] == '0) |-> (!req0_o && !req1_o));

    assert_wake_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[W_WAKE] == '0) |-> !wake_o);
endmodule

// File: tb/sim_ic_hub.sv
`timescale 1ns/1ps
// Directed bench for ic_hub: one task per scenario, each checking its results.
module sim_ic_hub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_pins = '0;
    logic        req0, req1, wake;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    ic_hub u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pins  (irq_pins),
        .req0_o    (req0),
        .req1_o    (req1),
        .wake_o    (wake)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string what, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(what, bus_rdata, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pin(input int n, input logic v);
        @(negedge clk);
        irq_pins[n] = v;
    endtask

    task automatic safe_idle;
        irq_pins = '0;
        wait_cyc(4);
        for (int i = 0; i < 7; i++) wr(8'h44 + 8'(i * 8), 32'hFFFF_FFFF);
        wr(8'h58, 32'hFFFF_FFFF);
        wr(8'h78, 32'hFFFF_FFFF);
        wr(8'h7C, 32'hFFFF_FFFF);
        wr(8'h80, 32'h0);
        wait_cyc(4);
    endtask

    task automatic t_reset;
        rd_chk("R10 cfg0", 8'h40, 0); rd_chk("R10 cfg1", 8'h48, 0);
        rd_chk("R10 cfg2", 8'h50, 0); rd_chk("R10 src", 8'h58, 0);
        rd_chk("R10 assign", 8'h60, 0); rd_chk("R10 wake", 8'h68, 0);
        rd_chk("R10 mask", 8'h70, 0); rd_chk("R10 rise", 8'h78, 0);
        rd_chk("R10 fall", 8'h7C, 0); rd_chk("R10 test", 8'h80, 0);
        chk("R10 req0", req0, 0); chk("R10 req1", req1, 0); chk("R10 wake", wake, 0);
    endtask

    task automatic t_init;
        safe_idle();
        rd_chk("R11 src all ones", 8'h58, 32'hFFFF_FFFF);
        rd_chk("R11 mask", 8'h70, 0);
        rd_chk("R11 pend0", 8'h54, 0);
        rd_chk("R11 pend1", 8'h5C, 0);
        chk("R11 req0", req0, 0); chk("R11 req1", req1, 0); chk("R11 wake", wake, 0);
    endtask

    task automatic t_setclr;
        wr(8'h70, 32'h0000_F0F0); wr(8'h70, 32'h0000_0F00);
        rd_chk("R2 mask set", 8'h70, 32'h0000_FFF0);
        wr(8'h74, 32'h0000_00F0);
        rd_chk("R2 mask clear", 8'h70, 32'h0000_FF00);
        wr(8'h70, 32'h0); wr(8'h74, 32'h0);
        rd_chk("R2 zero bits keep", 8'h70, 32'h0000_FF00);
        rd_chk("R3 clear addr reads 0", 8'h74, 0);
        wr(8'h74, 32'hFFFF_FFFF);
        wr(8'h48, 32'h3); wr(8'h4C, 32'h1);
        rd_chk("R2 cfg1 set/clr", 8'h48, 32'h2);
        wr(8'h4C, 32'h2);
        wr(8'h5C, 32'h1);
        rd_chk("R3 write at 0x5C clears src", 8'h58, 32'hFFFF_FFFE);
        wr(8'h58, 32'h1);
        wr(8'h50, 32'h100); wr(8'h54, 32'h100);
        rd_chk("R3 write at 0x54 clears cfg2", 8'h50, 0);
    endtask

    task automatic t_rising;
        safe_idle();
        wr(8'h40, 32'h8); wr(8'h70, 32'h8); wr(8'h60, 32'h8);
        pin(3, 1'b1);
        @(posedge clk); @(negedge clk); chk("R9 edge after 1", req0, 0);
        @(posedge clk); @(negedge clk); chk("R9 edge after 2", req0, 0);
        @(posedge clk); @(negedge clk); chk("R9 edge after 3", req0, 1);
        rd_chk("R7 pend0 rise", 8'h54, 32'h8);
        rd_chk("R7 pend1 empty", 8'h5C, 0);
        rd_chk("R5 rise latched", 8'h78, 32'h8);
        rd_chk("R5 no fall latch yet", 8'h7C, 0);
        pin(3, 1'b0); wait_cyc(4);
        rd_chk("R5 rise held", 8'h78, 32'h8);
        rd_chk("R1 fall ignored in rise mode", 8'h7C, 0);
        chk("R5 req0 held", req0, 1);
        wr(8'h78, 32'h8);
        rd_chk("R5 rise cleared", 8'h78, 0);
        chk("R5 req0 after clear", req0, 0);
    endtask

    task automatic t_falling;
        safe_idle();
        wr(8'h48, 32'h20); wr(8'h70, 32'h20);
        pin(5, 1'b1); wait_cyc(4);
        rd_chk("R1 rise ignored in fall mode", 8'h78, 0);
        chk("R1 req1 quiet on rise", req1, 0);
        pin(5, 1'b0); wait_cyc(4);
        rd_chk("R5 fall latched", 8'h7C, 32'h20);
        rd_chk("R7 pend1 fall", 8'h5C, 32'h20);
        chk("R7 req1 routed", req1, 1);
        chk("R7 req0 not routed", req0, 0);
        wr(8'h7C, 32'h20);
        chk("R5 req1 after clear", req1, 0);
    endtask

    task automatic t_both;
        safe_idle();
        wr(8'h48, 32'h80); wr(8'h40, 32'h80); wr(8'h70, 32'h80); wr(8'h60, 32'h80);
        pin(7, 1'b1); wait_cyc(4);
        rd_chk("R5 both: rise", 8'h78, 32'h80);
        rd_chk("R5 both: no fall", 8'h7C, 0);
        chk("R1 both req0", req0, 1);
        wr(8'h78, 32'h80);
        chk("R5 both cleared", req0, 0);
        pin(7, 1'b0); wait_cyc(4);
        rd_chk("R5 both: fall", 8'h7C, 32'h80);
        rd_chk("R5 both: rise clear", 8'h78, 0);
        chk("R1 both req0 fall", req0, 1);
        wr(8'h7C, 32'h80);
    endtask

    task automatic t_level;
        safe_idle();
        wr(8'h50, 32'h600); wr(8'h40, 32'h200); wr(8'h48, 32'h400);
        wr(8'h70, 32'h600); wr(8'h60, 32'h200);
        chk("R6 low level active at 0", req1, 1);
        rd_chk("R6 pend1 low", 8'h5C, 32'h400);
        pin(9, 1'b1);
        @(posedge clk); @(negedge clk); chk("R9 level after 1", req0, 0);
        @(posedge clk); @(negedge clk); chk("R9 level after 2", req0, 1);
        rd_chk("R6 pend0 high", 8'h54, 32'h200);
        pin(9, 1'b0);
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R6 high level drops by itself", req0, 0);
        pin(10, 1'b1); wait_cyc(4);
        chk("R6 low level drops", req1, 0);
        rd_chk("R6 no rise latch", 8'h78, 0);
        rd_chk("R6 no fall latch", 8'h7C, 0);
    endtask

    task automatic t_mask_wake;
        safe_idle();
        wr(8'h50, 32'h200); wr(8'h40, 32'h200); wr(8'h68, 32'h200);
        pin(9, 1'b1); wait_cyc(4);
        chk("R8 wake unmasked", wake, 1);
        chk("R7 masked req0", req0, 0);
        chk("R7 masked req1", req1, 0);
        wr(8'h6C, 32'h200);
        chk("R8 wake disabled", wake, 0);
        wr(8'h68, 32'h200);
        rd_chk("R2 wake readback", 8'h68, 32'h200);
        wr(8'h70, 32'h200);
        chk("R7 assign 0 -> req1", req1, 1);
        rd_chk("R7 pend1 word", 8'h5C, 32'h200);
        chk("R8 wake on", wake, 1);
    endtask

    task automatic t_disabled;
        safe_idle();
        wr(8'h50, 32'h1000); wr(8'h70, 32'h1000); wr(8'h60, 32'h1000);
        pin(12, 1'b1); wait_cyc(4);
        chk("R1 code 100 quiet", req0, 0);
        rd_chk("R1 code 100 no latch", 8'h78, 0);
        wr(8'h40, 32'h1000);
        chk("R1 code 101 active", req0, 1);
        wr(8'h48, 32'h1000);
        chk("R1 code 111 quiet", req0, 0);
        pin(12, 1'b0); wait_cyc(4);
        rd_chk("R1 code 111 no fall latch", 8'h7C, 0);
        chk("R1 code 111 stays quiet", req0, 0);
    endtask

    task automatic t_test_src;
        safe_idle();
        wr(8'h5C, 32'h4000);
        wr(8'h50, 32'h4000); wr(8'h40, 32'h4000); wr(8'h70, 32'h4000); wr(8'h60, 32'h4000);
        pin(14, 1'b1); wait_cyc(4);
        chk("R4 pin ignored", req0, 0);
        wr(8'h80, 32'h4000); wait_cyc(3);
        chk("R4 test drives source", req0, 1);
        rd_chk("R4 test readback", 8'h80, 32'h4000);
        pin(14, 1'b0); wait_cyc(4);
        chk("R4 pin still ignored", req0, 1);
        wr(8'h80, 32'h0); wait_cyc(3);
        chk("R4 test released", req0, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_init();
        t_setclr();
        t_rising();
        t_falling();
        t_both();
        t_level();
        t_mask_wake();
        t_disabled();
        t_test_src();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule